// File: doc/BRIEF.md
# Boot Stream Block Loader

This engine takes a byte-wide boot image over a valid/ready stream and places it into memory through a single-byte write port. The image is a chain of blocks. Each block starts with a ten-byte header that gives a 32-bit destination address, a 32-bit byte count and a 16-bit flag word. The flag word tells the engine what to do with the block: copy its payload, fill its range with zeros without reading any payload, or drop its payload. An init block can also ask an external agent to run code and report back before loading goes on.

When the block marked as last has finished, the engine stops taking bytes. It raises a done flag and drives a start address chosen by a flag bit of that last header. It also exports a 4-bit pin index from the flag word, for a host-wait handshake that is handled elsewhere. A block whose write range touches the protected scratch window makes the engine stop for good and raise an error.

Top module: `boot_block_loader`

## Requirements
- R1: Each header is 10 stream bytes: address, then count, then flags, with each field least significant byte first. After a synchronous reset, s_ready is 1 and done, error, call_req and mem_wr are 0, start_vec is 0xFFA0_8000 and wait_pin is 0.
- R2: A copy block (flag bits 0, 3 and 4 all clear) writes payload byte i to address ADDR+i. Each write is a single-cycle strobe that comes one cycle after the byte is accepted.
- R3: A block with flag bit 0 set takes no payload from the stream. It writes COUNT zero bytes to ADDR, ADDR+1 and onward, one per cycle, and holds s_ready low while doing so. Bit 0 takes priority over bit 4.
- R4: A block with flag bit 4 set and bit 0 clear accepts COUNT payload bytes and writes nothing.
- R5: A block that writes memory but has COUNT 0 writes nothing, and the next stream byte is taken as the start of the next header.
- R6: When a block with flag bit 3 set ends, call_req rises with call_addr equal to that block's ADDR and s_ready low. Both hold until call_ack is seen, and then the engine goes on.
- R7: When the block with flag bit 15 set ends (after its call return, if it is also an init block), done rises and s_ready stays low until reset. No further writes happen.
- R8: start_vec is 0xFFA0_0000 if flag bit 1 of the last-block header was 1, and 0xFFA0_8000 if it was 0.
- R9: wait_pin shows flag bits 8:5 of the most recently received header.
- R10: If a block that writes memory (bit 0 set, or bit 4 clear) has COUNT > 0 and its range ADDR..ADDR+COUNT-1 overlaps 0xFFB0_0000..0xFFB0_0FFF, then no byte of that block is written, error rises, and s_ready stays low until reset. Drop blocks are not checked.
- R11: A reset in the middle of a header discards the partial header, and the next byte is taken as the first byte of a new header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_data | input | 8 | Stream byte |
| s_valid | input | 1 | Stream byte valid |
| s_ready | output | 1 | Engine accepts a byte this cycle |
| mem_wr | output | 1 | Single-cycle memory write strobe |
| mem_addr | output | 32 | Write byte address |
| mem_data | output | 8 | Write byte value |
| call_req | output | 1 | Init code call request |
| call_addr | output | 32 | Entry address of the init block |
| call_ack | input | 1 | Init code has returned |
| done | output | 1 | Loading complete |
| start_vec | output | 32 | Start address chosen by the last block |
| wait_pin | output | 4 | Host-wait pin index from the latest header |
| error | output | 1 | Protected-window violation, terminal |

## Verification
The hardest situations to reach from the ports are blocks whose range lies just next to the protected window or just crosses into it, and a reset that arrives partway through a header. The bench builds these directly: one range ends exactly one byte below the window, one range crosses its last byte, and a drop block sits inside it. It also cuts a header off after four bytes with a reset. Constrained random chains of copy, zero, drop and init blocks, with random call-return delays and stray flag bits, cover the mix of block kinds.

// File: rtl/bl_pkg.sv
package bl_pkg;
  localparam int HDR_BYTES = 10;
  localparam int F_ZERO  = 0;
  localparam int F_VSEL  = 1;
  localparam int F_INIT  = 3;
  localparam int F_DROP  = 4;
  localparam int F_PINLO = 5;
  localparam int F_LAST  = 15;

  typedef enum logic [2:0] {
    ST_HDR, ST_COPY, ST_ZERO, ST_DROP, ST_CALL, ST_DONE, ST_ERR
  } bl_state_t;

  function automatic logic [31:0] pick_vector(input logic sel);
    return sel ? 32'hFFA0_0000 : 32'hFFA0_8000;
  endfunction

  // True when [a, a+n-1] overlaps [lo, hi]; empty ranges never overlap
  function automatic logic hits_window(input logic [31:0] a, input logic [31:0] n,
                                       input logic [31:0] lo, input logic [31:0] hi);
    logic [32:0] last;
    if (n == 32'd0) return 1'b0;
    last = {1'b0, a} + {1'b0, n} - 33'd1;
    return ({1'b0, a} <= {1'b0, hi}) && (last >= {1'b0, lo});
  endfunction

  function automatic bl_state_t after_block(input logic is_init, input logic is_last);
    if (is_init) return ST_CALL;
    if (is_last) return ST_DONE;
    return ST_HDR;
  endfunction
endpackage

// File: rtl/bl_hdr_collect.sv
module bl_hdr_collect #(
  parameter int NBYTES = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  take,
  input  logic [7:0]            byte_in,
  output logic                  hdr_last,
  output logic [NBYTES*8-1:0]   hdr_word
);
  localparam int IDX_W = $clog2(NBYTES);
  localparam int WORD_W = NBYTES * 8;

  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] shreg;

  assign hdr_last = take && (idx == IDX_W'(NBYTES - 1));
  assign hdr_word = {byte_in, shreg[WORD_W-1:8]};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx   <= '0;
      shreg <= '0;
    end else if (take) begin
      shreg <= hdr_word;
      idx   <= hdr_last ? '0 : idx + 1'b1;
    end
  end

  a_r1_index_bound: assert property (@(posedge clk) disable iff (rst)
    idx <= IDX_W'(NBYTES - 1));
  a_r11_restart: assert property (@(posedge clk)
    rst |=> idx == '0);
endmodule

// File: rtl/bl_write_port.sv
module bl_write_port (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [31:0] addr,
  input  logic [7:0]  data,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_wr   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
    end else begin
      mem_wr <= req;
      if (req) begin
        mem_addr <= addr;
        mem_data <= data;
      end
    end
  end

  a_r2_strobe_follows_req: assert property (@(posedge clk) disable iff (rst)
    req |=> mem_wr && mem_addr == $past(addr));
endmodule

// File: rtl/boot_block_loader.sv
module boot_block_loader
  import bl_pkg::*;
#(
  parameter logic [31:0] FORBID_LO = 32'hFFB0_0000,
  parameter logic [31:0] FORBID_HI = 32'hFFB0_0FFF
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [7:0]  s_data,
  input  logic        s_valid,
  output logic        s_ready,
  output logic        mem_wr,
  output logic [31:0] mem_addr,
  output logic [7:0]  mem_data,
  output logic        call_req,
  output logic [31:0] call_addr,
  input  logic        call_ack,
  output logic        done,
  output logic [31:0] start_vec,
  output logic [3:0]  wait_pin,
  output logic        error
);
  localparam int HW = HDR_BYTES * 8;

  bl_state_t   state;
  logic [31:0] cur_addr, remain, blk_addr;
  logic        blk_init, blk_last, vsel_q;
  logic [3:0]  pin_q;

  logic          take, hdr_last, wr_req, blk_end, hdr_writes, hdr_bad;
  logic [HW-1:0] hdr_word;
  logic [31:0]   h_addr, h_cnt;
  logic [15:0]   h_flg;
  logic [7:0]    wr_data;

  assign s_ready = (state == ST_HDR) || (state == ST_COPY) || (state == ST_DROP);
  assign take    = s_valid && s_ready;

  bl_hdr_collect #(.NBYTES(HDR_BYTES)) u_hdr (
    .clk(clk), .rst(rst), .take(take && state == ST_HDR),
    .byte_in(s_data), .hdr_last(hdr_last), .hdr_word(hdr_word)
  );

  assign h_addr = hdr_word[31:0];
  assign h_cnt  = hdr_word[63:32];
  assign h_flg  = hdr_word[79:64];

  logic unused_flag_bits;
  assign unused_flag_bits = ^{h_flg[14:9], h_flg[2]};

  assign hdr_writes = h_flg[F_ZERO] || !h_flg[F_DROP];
  assign hdr_bad    = hdr_writes && hits_window(h_addr, h_cnt, FORBID_LO, FORBID_HI);

  assign wr_req  = (state == ST_COPY && take) || (state == ST_ZERO);
  assign wr_data = (state == ST_ZERO) ? 8'h00 : s_data;
  assign blk_end = (((state == ST_COPY) || (state == ST_DROP)) && take && remain == 32'd1)
                 || ((state == ST_ZERO) && remain == 32'd1);

  bl_write_port u_wr (
    .clk(clk), .rst(rst), .req(wr_req), .addr(cur_addr), .data(wr_data),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HDR;
      cur_addr <= '0;
      remain   <= '0;
      blk_addr <= '0;
      blk_init <= 1'b0;
      blk_last <= 1'b0;
      vsel_q   <= 1'b0;
      pin_q    <= '0;
    end else begin
      unique case (state)
        ST_HDR: if (hdr_last) begin
          pin_q    <= h_flg[F_PINLO +: 4];
          if (h_flg[F_LAST]) vsel_q <= h_flg[F_VSEL];
          blk_init <= h_flg[F_INIT];
          blk_last <= h_flg[F_LAST];
          blk_addr <= h_addr;
          cur_addr <= h_addr;
          remain   <= h_cnt;
          if (hdr_bad)                state <= ST_ERR;
          else if (h_cnt == 32'd0)    state <= after_block(h_flg[F_INIT], h_flg[F_LAST]);
          else if (h_flg[F_ZERO])     state <= ST_ZERO;
          else if (h_flg[F_DROP])     state <= ST_DROP;
          else                        state <= ST_COPY;
        end
        ST_COPY, ST_DROP, ST_ZERO: begin
          if (wr_req || take) begin
            cur_addr <= cur_addr + 32'd1;
            remain   <= remain - 32'd1;
          end
          if (blk_end) state <= after_block(blk_init, blk_last);
        end
        ST_CALL: if (call_ack) state <= blk_last ? ST_DONE : ST_HDR;
        default: state <= state;
      endcase
    end
  end

  assign call_req  = (state == ST_CALL);
  assign call_addr = blk_addr;
  assign done      = (state == ST_DONE);
  assign error     = (state == ST_ERR);
  assign start_vec = pick_vector(vsel_q);
  assign wait_pin  = pin_q;

  a_r7_done_sticks: assert property (@(posedge clk) disable iff (rst)
    done |=> done && !s_ready);
  a_r10_error_sticks: assert property (@(posedge clk) disable iff (rst)
    error |=> error && !s_ready && !mem_wr);
  a_r6_call_holds: assert property (@(posedge clk) disable iff (rst)
    call_req && !call_ack |=> call_req && $stable(call_addr));
  a_r3_zero_stalls: assert property (@(posedge clk) disable iff (rst)
    mem_wr && mem_data != 8'h00 |-> $past(take));
  a_r1_terminal_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && error));
endmodule

// File: tb/boot_block_loader_test.sv
module boot_block_loader_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] WIN_LO = 32'hFFB0_0000;
  localparam logic [31:0] WIN_HI = 32'hFFB0_0FFF;

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0, call_ack = 1'b0;
  logic s_ready, mem_wr, call_req, done, error;
  logic [31:0] mem_addr, call_addr, start_vec;
  logic [7:0] mem_data;
  logic [3:0] wait_pin;

  boot_block_loader uut (
    .clk(clk), .rst(rst), .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
    .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_data(mem_data),
    .call_req(call_req), .call_addr(call_addr), .call_ack(call_ack),
    .done(done), .start_vec(start_vec), .wait_pin(wait_pin), .error(error)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]  stm[$];
  logic [31:0] exp_a[$], got_a[$], exp_c[$], got_c[$];
  logic [7:0]  exp_d[$], got_d[$];
  logic        exp_done, exp_err, built_stop;
  logic [31:0] exp_vec;
  logic [3:0]  exp_pin;
  int checks = 0, errors = 0;
  bit finished = 0;

  function automatic logic [31:0] ref_vec(input logic b);
    return b ? 32'hFFA0_0000 : 32'hFFA0_8000;
  endfunction

  function automatic bit ref_forbid(input logic [31:0] a, input logic [31:0] c);
    longint unsigned s, e;
    s = longint'(a);
    e = s + longint'(c) - 1;
    if (c == 0) return 0;
    return !(e < longint'(WIN_LO) || s > longint'(WIN_HI));
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic clear_model();
    stm.delete(); exp_a.delete(); exp_d.delete(); exp_c.delete();
    got_a.delete(); got_d.delete(); got_c.delete();
    exp_done = 0; exp_err = 0; built_stop = 0;
    exp_vec = 32'hFFA0_8000; exp_pin = 0;
  endtask

  task automatic add_block(input logic [31:0] a, input logic [31:0] c, input logic [15:0] f);
    logic [79:0] h;
    bit zero, drop;
    if (built_stop) return;
    h = {f, c, a};
    for (int i = 0; i < 10; i++) stm.push_back(h[i*8 +: 8]);
    exp_pin = f[8:5];
    if (f[15]) exp_vec = ref_vec(f[1]);
    zero = f[0];
    drop = f[4] && !zero;
    if (!drop && ref_forbid(a, c)) begin
      exp_err = 1; built_stop = 1; return;
    end
    for (int i = 0; i < int'(c); i++) begin
      if (zero) begin
        exp_a.push_back(a + i); exp_d.push_back(8'h00);
      end else begin
        logic [7:0] b;
        b = 8'($urandom);
        stm.push_back(b);
        if (!drop) begin exp_a.push_back(a + i); exp_d.push_back(b); end
      end
    end
    if (f[3]) exp_c.push_back(a);
    if (f[15]) begin exp_done = 1; built_stop = 1; end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; s_valid = 0;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    forever begin
      @(negedge clk);
      s_valid = 1; s_data = b;
      if (s_ready) begin @(posedge clk); break; end
    end
  endtask

  task automatic play();
    foreach (stm[i]) send_byte(stm[i]);
    @(negedge clk);
    s_valid = 0;
    for (int k = 0; k < 400 && !(done || error); k++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input string nm);
    chk(got_a.size() == exp_a.size(), {"R2 write count ", nm}, got_a.size(), exp_a.size());
    for (int i = 0; i < exp_a.size() && i < got_a.size(); i++) begin
      chk(got_a[i] == exp_a[i], {"R2 write addr ", nm}, got_a[i], exp_a[i]);
      chk(got_d[i] == exp_d[i], {"R3 write data ", nm}, got_d[i], exp_d[i]);
    end
    chk(got_c.size() == exp_c.size(), {"R6 call count ", nm}, got_c.size(), exp_c.size());
    for (int i = 0; i < exp_c.size() && i < got_c.size(); i++)
      chk(got_c[i] == exp_c[i], {"R6 call addr ", nm}, got_c[i], exp_c[i]);
    chk(done == exp_done, {"R7 done ", nm}, done, exp_done);
    chk(error == exp_err, {"R10 error ", nm}, error, exp_err);
    chk(start_vec == exp_vec, {"R8 start_vec ", nm}, start_vec, exp_vec);
    chk(wait_pin == exp_pin, {"R9 wait_pin ", nm}, wait_pin, exp_pin);
  endtask

  // write monitor
  initial forever begin
    @(negedge clk);
    if (!rst && mem_wr) begin got_a.push_back(mem_addr); got_d.push_back(mem_data); end
  end

  // init call responder with random return delay
  initial begin
    int dly;
    dly = 1;
    forever begin
      @(negedge clk);
      call_ack = 0;
      if (!rst && call_req) begin
        if (dly == 0) begin
          call_ack = 1;
          got_c.push_back(call_addr);
          dly = $urandom % 4;
        end else dly--;
      end
    end
  end

  task automatic finish_run();
    if (finished) return;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    clear_model();
    do_reset();
    // R1 reset state
    @(negedge clk);
    chk(s_ready == 1, "R1 ready after reset", s_ready, 1);
    chk(!done && !error && !call_req && !mem_wr, "R1 flags after reset",
        {done, error, call_req, mem_wr}, 0);
    chk(start_vec == 32'hFFA0_8000, "R1 start_vec after reset", start_vec, 32'hFFA0_8000);
    chk(wait_pin == 0, "R1 wait_pin after reset", wait_pin, 0);

    // Directed: every block kind, zero priority over drop, count zero, init
    clear_model();
    add_block(32'h0000_1000, 5, 16'h0000);            // R2 copy
    add_block(32'h0000_2000, 4, 16'h0001);            // R3 zero fill
    add_block(32'h0000_3000, 3, 16'h0010);            // R4 drop
    add_block(32'h0000_3800, 2, 16'h0011);            // R3 zero wins over drop
    add_block(32'h0000_4000, 0, 16'h0000);            // R5 count zero
    add_block(32'hFFA0_1000, 3, 16'h0008);            // R6 init call
    add_block(32'h0000_5000, 2, 16'h8122);            // R7 R8 R9 last, vec 1, pin 9
    play();
    verify("directed");
    // R7: further input is refused
    s_valid = 1; s_data = 8'hAA;
    repeat (4) @(negedge clk);
    chk(s_ready == 0, "R7 no accept after done", s_ready, 0);
    chk(got_a.size() == exp_a.size(), "R7 no write after done", got_a.size(), exp_a.size());
    s_valid = 0;

    // R10 boundary: range ending just below window is fine, drop inside window is fine,
    // then a copy crossing into the window's last byte is refused
    do_reset(); clear_model();
    add_block(32'hFFAF_FFFC, 4, 16'h0000);
    add_block(32'hFFB0_0800, 6, 16'h0030);
    add_block(32'hFFB0_0FFF, 3, 16'h0040);
    play();
    verify("window");
    s_valid = 1;
    repeat (4) @(negedge clk);
    chk(s_ready == 0, "R10 no accept after error", s_ready, 0);
    chk(got_a.size() == exp_a.size(), "R10 no write after error", got_a.size(), exp_a.size());
    s_valid = 0;

    // R10 zero fill starting below and reaching into the window
    do_reset(); clear_model();
    add_block(32'hFFAF_FFF0, 32'h20, 16'h0001);
    play();
    verify("zero into window");

    // R11 reset in mid header, then last block that is also an init block
    do_reset(); clear_model();
    for (int i = 0; i < 4; i++) send_byte(8'h5A);
    @(negedge clk); s_valid = 0;
    do_reset();
    add_block(32'h0000_0100, 3, 16'h0000);
    add_block(32'h0000_0200, 1, 16'h8048);            // R6 R7 init + last, vec 0, pin 2
    play();
    verify("R11 restart");

    // Constrained random chains
    for (int t = 0; t < 25; t++) begin
      int nb;
      do_reset(); clear_model();
      nb = 1 + $urandom % 5;
      for (int b = 0; b < nb; b++) begin
        logic [15:0] f;
        logic [31:0] a, c;
        int kind;
        f = 16'(($urandom & 32'h7E04));               // stray bits 14:9 and 2
        f[8:5] = 4'($urandom);
        kind = $urandom % 5;
        case (kind)
          1: f[0] = 1;
          2: f[4] = 1;
          3: f[3] = 1;
          4: begin f[0] = 1; f[4] = 1; end
          default: ;
        endcase
        if (b == nb - 1) begin f[15] = 1; f[1] = 1'($urandom); end
        a = $urandom & 32'h7FFF_FFF0;
        c = $urandom % 7;
        add_block(a, c, f);
      end
      play();
      verify("random");
    end

    finish_run();
  end
endmodule